// File: doc/BRIEF.md
# Streaming Sample Histogram

This block counts how often incoming sample values fall into each of a fixed number of equal-width bins. The samples arrive on a streaming input with a data word, a valid flag and a periodic sync pulse. The span between two sync pulses is one measurement interval. The bin index is the most significant log2(NBINS) bits of each valid sample. Each such sample increments that bin's counter by read-modify-write.

Two count pages are kept. One page accumulates the running interval. The other holds the finished histogram of the previous interval, which a plain read port returns as zero-extended 32-bit words one clock after the address is presented. At every sync the two pages trade roles. The newly active page is then swept to zero one bin per clock. Valid samples that arrive during the sync cycle or the sweep are discarded, which costs at most NBINS + 1 samples per interval.

Top module: `sample_hist`

## Requirements
- R1: Only samples with the valid input high are counted. A counted sample increments the bin whose index equals the top log2(NBINS) bits of its value.
- R2: A sync pulse closes the running interval. Afterwards, the read port returns that interval's final count for every bin.
- R3: The read port keeps returning the last completed interval while a new interval accumulates. After the next sync, it returns the newer interval instead.
- R4: After each sync, the newly active page has every bin set to zero, including bins that no sample addresses, so no count from an older interval survives.
- R5: A valid sample arriving in the same cycle as sync is discarded. So is a valid sample in any of the NBINS cycles after it. The valid sample in cycle sync+NBINS+1 is counted.
- R6: Valid samples in consecutive cycles that hit the same bin are all counted, with no lost increment.
- R7: The counter width is ceil(log2(NDATA)) bits. A bin saturates at 2**width-1 instead of wrapping.
- R8: A read address presented before a clock edge yields its count on rd_data after that edge, with all bits above the counter width at zero.
- R9: Until the first sync after reset, rd_data is zero for every address, whatever samples have arrived.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_data | input | W_DATA | Sample value |
| in_valid | input | 1 | Sample present this cycle |
| in_sync | input | 1 | Interval boundary pulse |
| rd_addr | input | log2(NBINS) | Bin to read from the completed histogram |
| rd_data | output | 32 | Count of the addressed bin, zero-extended |

## Verification
A wrong page select, or a clear sweep that misses a bin, shows up at the read port in a predictable place. The first read after the following sync returns either a stale count from two intervals back or a count from the interval still running. A lost forward shows up as a bin total one short per back-to-back pair once that interval is read out. An off-by-one in the discard window moves a whole count into or out of a bin. The sweeps put every sample value into the counts. A second interval then leaves most of the bins the first interval used untouched, so any stale count would be read out.

// File: rtl/hist_pkg.sv
package hist_pkg;
  localparam int RD_W = 32;
endpackage

// File: rtl/hist_page.sv
module hist_page #(
  parameter int CNT_W = 28,
  parameter int NBINS = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(NBINS)-1:0] waddr,
  input  logic [CNT_W-1:0]         wdata,
  input  logic [$clog2(NBINS)-1:0] ra_addr,
  output logic [CNT_W-1:0]         ra_data,
  input  logic [$clog2(NBINS)-1:0] rb_addr,
  output logic [CNT_W-1:0]         rb_data
);
  logic [CNT_W-1:0] mem [NBINS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/hist_ctrl.sv
module hist_ctrl #(
  parameter int NBINS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_i,
  output logic                     page_o,
  output logic                     busy_o,
  output logic [$clog2(NBINS)-1:0] idx_o,
  output logic                     have_o
);
  localparam int BIN_W = $clog2(NBINS);
  localparam logic [BIN_W-1:0] LAST = BIN_W'(NBINS - 1);

  logic             page_q, page_n;
  logic             busy_q, busy_n;
  logic             have_q, have_n;
  logic [BIN_W-1:0] idx_q, idx_n;

  always_comb begin
    page_n = page_q;
    busy_n = busy_q;
    idx_n  = idx_q;
    have_n = have_q;
    if (sync_i) begin
      page_n = ~page_q;
      busy_n = 1'b1;
      idx_n  = '0;
      have_n = 1'b1;
    end else if (busy_q) begin
      idx_n = idx_q + 1'b1;
      if (idx_q == LAST) busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= 1'b0;
      busy_q <= 1'b1;
      idx_q  <= '0;
      have_q <= 1'b0;
    end else begin
      page_q <= page_n;
      busy_q <= busy_n;
      idx_q  <= idx_n;
      have_q <= have_n;
    end
  end

  assign page_o = page_q;
  assign busy_o = busy_q;
  assign idx_o  = idx_q;
  assign have_o = have_q;

  p_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> page_q != $past(page_q));
  p_clear_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_i |=> busy_q && idx_q == '0);
  p_clear_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && idx_q == LAST && !sync_i |=> !busy_q);
endmodule

// File: rtl/sample_hist.sv
module sample_hist
  import hist_pkg::*;
#(
  parameter int W_DATA = 12,
  parameter int NBINS  = 64,
  parameter int NDATA  = 200000000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [W_DATA-1:0]        in_data,
  input  logic                     in_valid,
  input  logic                     in_sync,
  input  logic [$clog2(NBINS)-1:0] rd_addr,
  output logic [RD_W-1:0]          rd_data
);
  localparam int BIN_W = $clog2(NBINS);
  localparam int CNT_W = $clog2(NDATA);
  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  logic             page, clr_busy, have;
  logic [BIN_W-1:0] clr_idx;

  hist_ctrl #(.NBINS(NBINS)) i_ctrl (
    .clk(clk), .rst_n(rst_i_n), .sync_i(in_sync),
    .page_o(page), .busy_o(clr_busy), .idx_o(clr_idx), .have_o(have)
  );

  // stage 0: accept and issue read
  logic             accept;
  logic [BIN_W-1:0] bin;
  assign accept = in_valid & ~in_sync & ~clr_busy;
  assign bin    = in_data[W_DATA-1 -: BIN_W];

  // stage 1 and last-write registers
  logic             s1_vld, s1_page, last_en, last_page;
  logic [BIN_W-1:0] s1_bin, last_bin;
  logic [CNT_W-1:0] last_val;
  logic [CNT_W-1:0] base, inc;
  logic [CNT_W-1:0] ra_data [2];
  logic [CNT_W-1:0] rb_data [2];

  always_comb begin
    if (last_en && last_bin == s1_bin && last_page == s1_page) base = last_val;
    else                                                      base = ra_data[s1_page];
    inc = (base == MAXC) ? MAXC : base + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      s1_vld  <= 1'b0;
      last_en <= 1'b0;
    end else begin
      s1_vld  <= accept;
      last_en <= s1_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_bin  <= bin;
      s1_page <= page;
    end
    if (s1_vld) begin
      last_bin  <= s1_bin;
      last_page <= s1_page;
      last_val  <= inc;
    end
  end

  // two pages
  for (genvar p = 0; p < 2; p++) begin : g_page
    logic             we;
    logic [BIN_W-1:0] waddr;
    logic [CNT_W-1:0] wdata;
    logic             clr_here;
    assign clr_here = clr_busy && (page == 1'(p));
    assign we       = clr_here || (s1_vld && s1_page == 1'(p));
    assign waddr    = clr_here ? clr_idx : s1_bin;
    assign wdata    = clr_here ? '0 : inc;
    hist_page #(.CNT_W(CNT_W), .NBINS(NBINS)) i_page (
      .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
      .ra_addr(bin), .ra_data(ra_data[p]),
      .rb_addr(rd_addr), .rb_data(rb_data[p])
    );
  end

  // readout of the preserved page
  logic rd_sel_q, rd_ok_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rd_sel_q <= 1'b0;
      rd_ok_q  <= 1'b0;
    end else begin
      rd_sel_q <= ~page;
      rd_ok_q  <= have;
    end
  end
  assign rd_data = rd_ok_q ? RD_W'(rb_data[rd_sel_q]) : '0;

  p_no_clash_r4: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(s1_vld && clr_busy));
  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_i_n)
    in_valid && (in_sync || clr_busy) |=> !s1_vld);
  p_fwd_r6: assert property (@(posedge clk) disable iff (!rst_i_n)
    s1_vld && last_en && last_bin == s1_bin && last_page == s1_page && last_val != MAXC
    |-> inc == CNT_W'(last_val + 1'b1));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    s1_vld |-> inc != '0);
  p_zero_early_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !have |=> rd_data == '0);
endmodule

// File: tb/test_sample_hist.sv
module test_sample_hist;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 6;
  localparam int NB = 8;
  localparam int ND = 40;   // counter width 6, ceiling 63
  localparam int BW = $clog2(NB);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [W-1:0]  in_data;
  logic          in_valid, in_sync;
  logic [BW-1:0] rd_addr;
  logic [31:0]   rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_hist #(.W_DATA(W), .NBINS(NB), .NDATA(ND)) i_sample_hist (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_sync(in_sync), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int d, input bit v);
    @(negedge clk);
    in_data = W'(d); in_valid = v; in_sync = 1'b0;
  endtask

  task automatic sync_pulse(input int d, input bit v);
    @(negedge clk);
    in_data = W'(d); in_valid = v; in_sync = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(0, 1'b0);
  endtask

  task automatic read_bin(input int idx, input int exp, input string req);
    @(negedge clk);
    rd_addr = BW'(idx);
    @(negedge clk);
    check(req, rd_data, 32'(exp));
  endtask

  initial begin
    int exp1 [NB];
    rst_n = 1'b0; in_data = '0; in_valid = 1'b0; in_sync = 1'b0; rd_addr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    idle(20);

    // R9: zero after reset
    for (int b = 0; b < NB; b++) read_bin(b, 0, "R9 reset");

    // interval 1: sweep every value twice, interleaved with invalid samples (R1)
    for (int b = 0; b < NB; b++) exp1[b] = 0;
    for (int r = 0; r < 2; r++)
      for (int v = 0; v < (1 << W); v++) begin
        send(v, 1'b1);
        exp1[v >> (W - BW)]++;
        send((1 << W) - 1, 1'b0);
      end
    idle(2);
    // R9: still zero before first sync
    for (int b = 0; b < NB; b++) read_bin(b, 0, "R9 pre-sync");

    sync_pulse(0, 1'b0);
    idle(NB + 3);
    for (int b = 0; b < NB; b++) read_bin(b, exp1[b], "R1/R2/R8 interval1");

    // interval 2: back-to-back same bin, then alternating bins (R6)
    for (int i = 0; i < 20; i++) send((5 << (W - BW)) | (i & 7), 1'b1);
    for (int i = 0; i < 4; i++) begin
      send(2 << (W - BW), 1'b1);
      send(3 << (W - BW), 1'b1);
    end
    idle(2);
    // R3: readout unchanged mid-interval
    for (int b = 0; b < NB; b++) read_bin(b, exp1[b], "R3 hold");

    // sync carrying a valid sample, then the discard window (R5)
    sync_pulse(0, 1'b1);
    for (int i = 0; i < NB; i++) send(1, 1'b1);
    send(2, 1'b1);      // cycle sync+NB+1: counted into bin 0
    idle(1);
    for (int b = 0; b < NB; b++)
      read_bin(b, (b == 5) ? 20 : (b == 2 || b == 3) ? 4 : 0, "R3/R6 interval2");

    // interval 3: saturate bin 7 (R7); bins 1..6 must be clear (R4)
    for (int i = 0; i < 70; i++) send((7 << (W - BW)) | (i & 7), 1'b1);
    idle(2);
    sync_pulse(0, 1'b0);
    idle(NB + 3);
    for (int b = 0; b < NB; b++)
      read_bin(b, (b == 0) ? 1 : (b == 7) ? 63 : 0, "R4/R5/R7 interval3");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule